// File: doc/BRIEF.md
# Processor Reset and Strap Sequencer

This block sits on the system side of a host processor. It produces the processor's two active-low reset lines: a cold reset that fully initialises the processor and a warm reset that only restarts its logic. Both lines are timed by counting system clock cycles. A power-good input starts the sequence. After that, single-cycle requests can start a cold reset or a warm reset while the processor runs. Release has two phases. First the cold line is held for a long count. Then the warm line is held for a shorter count after the cold line has let go. One cycle after the warm line releases, a ready flag rises.

At the start of every cold reset, the block samples a group of configuration inputs into strap registers and drives those values to the processor. The straps stay frozen until the next cold reset begins. From the frozen straps, the block reports which bus protocol the processor will choose. It flags strap combinations that select no protocol, and it gives the clock multiplier as twice the ratio.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: When `rst` is high or `pwr_ok` is low at a clock edge, `cold_rst_n`, `warm_rst_n` and `ready` are all 0 after that edge.
- R2: After the last edge that sees a restart (reset, power loss or an accepted cold request), `cold_rst_n` stays 0 for exactly COLD_HOLD clock cycles. `warm_rst_n` stays 0 through that whole time.
- R3: After `cold_rst_n` rises, `cold_rst_n` stays 1 and `warm_rst_n` stays 0 for exactly WARM_HOLD more cycles. Then `warm_rst_n` rises.
- R4: A `warm_req` pulse while ready drives `warm_rst_n` low for exactly WARM_HOLD cycles. `cold_rst_n` stays 1 throughout.
- R5: `ready` rises one clock cycle after `warm_rst_n` rises. It stays 0 while either reset line is low.
- R6: A drop of `pwr_ok` at any point, including during the warm hold, restarts the full cold hold from the beginning.
- R7: `cold_req` and `warm_req` are ignored while a sequence is running (ready low). If both arrive together while ready, the cold request wins.
- R8: Each strap output equals the matching `cfg_*` input as sampled on the edge that starts a cold reset.
- R9: Changes on `cfg_*` during a warm reset or while running do not change any strap output, `proto`, `cfg_err` or `div_x2`.
- R10: `proto` is decoded from the frozen straps. Inorder=0 gives 3 (out-of-order return), whatever the other straps are. With inorder=1, {dw_off,vo_hold,bus64} = 111 gives 0 (64-bit legacy), 110 gives 1 (32-bit native) and 000 gives 2 (32-bit doubleword block).
- R11: Any other strap combination with inorder=1 gives `proto` = 7 and sets `cfg_err` to 1. Every listed combination gives `cfg_err` = 0.
- R12: `div_x2` equals the frozen 3-bit divide strap plus 4, which covers 4 to 11 for codes 000 to 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supplies good; low forces a full restart |
| cold_req | input | 1 | Cold reset request pulse |
| warm_req | input | 1 | Warm reset request pulse |
| cfg_bus64 | input | 1 | Bus width level to strap (1 = 64 bits) |
| cfg_big_end | input | 1 | Byte order level to strap (1 = big endian) |
| cfg_tmr_irq | input | 1 | Top interrupt source level to strap (1 = timer) |
| cfg_vo_hold | input | 1 | Valid-out hold level (1 = stays active while the address cycle stalls) |
| cfg_dw_off | input | 1 | Doubleword block transfer level (1 = disabled) |
| cfg_inorder | input | 1 | Return order level (1 = normal, 0 = out of order) |
| cfg_div | input | 3 | Clock ratio code |
| cold_rst_n | output | 1 | Cold reset to processor, active low |
| warm_rst_n | output | 1 | Warm reset to processor, active low |
| ready | output | 1 | Sequence complete, processor running |
| strap_bus64 | output | 1 | Frozen bus width strap |
| strap_big_end | output | 1 | Frozen byte order strap |
| strap_tmr_irq | output | 1 | Frozen interrupt source strap |
| strap_vo_hold | output | 1 | Frozen valid-out hold strap |
| strap_dw_off | output | 1 | Frozen doubleword strap |
| strap_inorder | output | 1 | Frozen return order strap |
| strap_div | output | 3 | Frozen clock ratio code |
| proto | output | 3 | Decoded protocol code |
| cfg_err | output | 1 | Strap combination selects no protocol |
| div_x2 | output | 4 | Clock ratio times two |

## Verification
The bench counts the exact number of cycles each reset line stays low. A counter that is off by one, or that does not clear between phases, shows up as a wrong hold length. Power is dropped in the middle of the warm hold, to catch a design that resumes from the warm phase instead of restarting the long cold count. Requests are injected during a running cold hold, which exposes a design that restarts its counter or reacts when it should ignore them. Configuration inputs are changed during a warm reset, to catch straps that track their inputs instead of freezing. A table of strap patterns then covers every protocol code, the invalid combinations and all divide codes.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int DIV_W = 3;

  typedef enum logic [1:0] {
    ST_COLD = 2'd0,
    ST_WARM = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

  typedef enum logic [2:0] {
    PR_LEGACY64 = 3'd0,
    PR_NATIVE32 = 3'd1,
    PR_DWBLOCK  = 3'd2,
    PR_OOO      = 3'd3,
    PR_INVALID  = 3'd7
  } proto_e;

  typedef struct packed {
    logic             inorder;
    logic             dw_off;
    logic             vo_hold;
    logic             bus64;
    logic             big_end;
    logic             tmr_irq;
    logic [DIV_W-1:0] div;
  } strap_t;
endpackage

// File: rtl/rsq_fsm.sv
module rsq_fsm #(
  parameter int COLD_HOLD = 65536,
  parameter int WARM_HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic cold_req,
  input  logic warm_req,
  output logic capture,
  output logic cold_n,
  output logic warm_n,
  output logic ready
);
  import rsq_pkg::*;

  localparam int MAXH = (COLD_HOLD > WARM_HOLD) ? COLD_HOLD : WARM_HOLD;
  localparam int CNT_W = $clog2(MAXH + 1);
  localparam logic [CNT_W-1:0] COLD_LAST = CNT_W'(COLD_HOLD - 1);
  localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARM_HOLD - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  // a restart point: every one of these begins a fresh cold hold
  assign capture = rst | ~pwr_ok | ((state == ST_RUN) & cold_req);

  always_ff @(posedge clk) begin
    if (capture) begin
      state  <= ST_COLD;
      cnt    <= '0;
      cold_n <= 1'b0;
      warm_n <= 1'b0;
      ready  <= 1'b0;
    end else begin
      case (state)
        ST_COLD: begin
          if (cnt == COLD_LAST) begin
            state  <= ST_WARM;
            cnt    <= '0;
            cold_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WARM: begin
          if (cnt == WARM_LAST) begin
            state  <= ST_RUN;
            cnt    <= '0;
            warm_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (warm_req) begin
            state  <= ST_WARM;
            cnt    <= '0;
            warm_n <= 1'b0;
            ready  <= 1'b0;
          end else begin
            ready <= 1'b1;
          end
        end
        default: begin
          state <= ST_COLD;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rsq_strap_latch.sv
module rsq_strap_latch (
  input  logic            clk,
  input  logic            capture,
  input  rsq_pkg::strap_t cfg,
  output rsq_pkg::strap_t held
);
  always_ff @(posedge clk) begin
    if (capture) held <= cfg;
  end
endmodule

// File: rtl/rsq_proto_decode.sv
module rsq_proto_decode (
  input  logic                       clk,
  input  logic                       rst,
  input  rsq_pkg::strap_t            s,
  output logic [2:0]                 proto,
  output logic                       err,
  output logic [rsq_pkg::DIV_W:0]    div_x2
);
  import rsq_pkg::*;

  proto_e           p_nx;
  logic [DIV_W:0]   d_nx;

  always_comb begin
    if (!s.inorder) begin
      p_nx = PR_OOO;
    end else begin
      case ({s.dw_off, s.vo_hold, s.bus64})
        3'b111:  p_nx = PR_LEGACY64;
        3'b110:  p_nx = PR_NATIVE32;
        3'b000:  p_nx = PR_DWBLOCK;
        default: p_nx = PR_INVALID;
      endcase
    end
    d_nx = {1'b0, s.div} + (DIV_W+1)'(4);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      proto  <= 3'(PR_INVALID);
      err    <= 1'b0;
      div_x2 <= '0;
    end else begin
      proto  <= 3'(p_nx);
      err    <= (p_nx == PR_INVALID);
      div_x2 <= d_nx;
    end
  end
endmodule

// File: rtl/cpu_reset_sequencer.sv
module cpu_reset_sequencer #(
  parameter int COLD_HOLD = 65536,
  parameter int WARM_HOLD = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_ok,
  input  logic       cold_req,
  input  logic       warm_req,
  input  logic       cfg_bus64,
  input  logic       cfg_big_end,
  input  logic       cfg_tmr_irq,
  input  logic       cfg_vo_hold,
  input  logic       cfg_dw_off,
  input  logic       cfg_inorder,
  input  logic [2:0] cfg_div,
  output logic       cold_rst_n,
  output logic       warm_rst_n,
  output logic       ready,
  output logic       strap_bus64,
  output logic       strap_big_end,
  output logic       strap_tmr_irq,
  output logic       strap_vo_hold,
  output logic       strap_dw_off,
  output logic       strap_inorder,
  output logic [2:0] strap_div,
  output logic [2:0] proto,
  output logic       cfg_err,
  output logic [3:0] div_x2
);
  import rsq_pkg::*;

  logic   capture;
  strap_t cfg_s;
  strap_t held_s;

  assign cfg_s = '{inorder: cfg_inorder, dw_off: cfg_dw_off, vo_hold: cfg_vo_hold,
                   bus64: cfg_bus64, big_end: cfg_big_end, tmr_irq: cfg_tmr_irq,
                   div: cfg_div};

  rsq_fsm #(.COLD_HOLD(COLD_HOLD), .WARM_HOLD(WARM_HOLD)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .pwr_ok   (pwr_ok),
    .cold_req (cold_req),
    .warm_req (warm_req),
    .capture  (capture),
    .cold_n   (cold_rst_n),
    .warm_n   (warm_rst_n),
    .ready    (ready)
  );

  rsq_strap_latch u_latch (
    .clk     (clk),
    .capture (capture),
    .cfg     (cfg_s),
    .held    (held_s)
  );

  rsq_proto_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .s      (held_s),
    .proto  (proto),
    .err    (cfg_err),
    .div_x2 (div_x2)
  );

  assign strap_bus64   = held_s.bus64;
  assign strap_big_end = held_s.big_end;
  assign strap_tmr_irq = held_s.tmr_irq;
  assign strap_vo_hold = held_s.vo_hold;
  assign strap_dw_off  = held_s.dw_off;
  assign strap_inorder = held_s.inorder;
  assign strap_div     = held_s.div;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker (
  input logic       clk,
  input logic       rst,
  input logic       pwr_ok,
  input logic       cold_rst_n,
  input logic       warm_rst_n,
  input logic       ready,
  input logic [8:0] straps
);
  AST_PWR_LOSS_RESTART: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (!cold_rst_n && !warm_rst_n && !ready)); // R6

  AST_WARM_COVERS_COLD: assert property (@(posedge clk) disable iff (rst)
    !cold_rst_n |-> !warm_rst_n); // R2

  AST_WARM_TRAILS_COLD: assert property (@(posedge clk) disable iff (rst)
    $rose(cold_rst_n) |-> !warm_rst_n); // R3

  AST_READY_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cold_rst_n && warm_rst_n)); // R5

  AST_READY_AFTER_WARM: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(warm_rst_n)); // R5

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cold_rst_n |-> $stable(straps)); // R9
endmodule

bind cpu_reset_sequencer rsq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_ok     (pwr_ok),
  .cold_rst_n (cold_rst_n),
  .warm_rst_n (warm_rst_n),
  .ready      (ready),
  .straps     ({strap_inorder, strap_dw_off, strap_vo_hold, strap_bus64,
                strap_big_end, strap_tmr_irq, strap_div})
);

// File: tb/cpu_reset_sequencer_tb.sv
module cpu_reset_sequencer_tb;
  localparam int CH = 40;
  localparam int WH = 6;

  logic clk = 1'b0;
  logic rst, pwr_ok, cold_req, warm_req;
  logic cfg_bus64, cfg_big_end, cfg_tmr_irq, cfg_vo_hold, cfg_dw_off, cfg_inorder;
  logic [2:0] cfg_div;
  logic cold_rst_n, warm_rst_n, ready;
  logic strap_bus64, strap_big_end, strap_tmr_irq, strap_vo_hold, strap_dw_off, strap_inorder;
  logic [2:0] strap_div, proto;
  logic cfg_err;
  logic [3:0] div_x2;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  cpu_reset_sequencer #(.COLD_HOLD(CH), .WARM_HOLD(WH)) u_dut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .cold_req(cold_req), .warm_req(warm_req),
    .cfg_bus64(cfg_bus64), .cfg_big_end(cfg_big_end), .cfg_tmr_irq(cfg_tmr_irq),
    .cfg_vo_hold(cfg_vo_hold), .cfg_dw_off(cfg_dw_off), .cfg_inorder(cfg_inorder),
    .cfg_div(cfg_div), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .ready(ready),
    .strap_bus64(strap_bus64), .strap_big_end(strap_big_end), .strap_tmr_irq(strap_tmr_irq),
    .strap_vo_hold(strap_vo_hold), .strap_dw_off(strap_dw_off), .strap_inorder(strap_inorder),
    .strap_div(strap_div), .proto(proto), .cfg_err(cfg_err), .div_x2(div_x2)
  );

  // {inorder, dw_off, vo_hold, bus64, div[2:0], proto[2:0], err, div_x2[3:0]}
  localparam logic [14:0] VEC [8] = '{
    {4'b1111, 3'd0, 3'd0, 1'b0, 4'd4},
    {4'b1110, 3'd1, 3'd1, 1'b0, 4'd5},
    {4'b1000, 3'd2, 3'd2, 1'b0, 4'd6},
    {4'b0111, 3'd3, 3'd3, 1'b0, 4'd7},
    {4'b0000, 3'd4, 3'd3, 1'b0, 4'd8},
    {4'b1100, 3'd5, 3'd7, 1'b1, 4'd9},
    {4'b1011, 3'd6, 3'd7, 1'b1, 4'd10},
    {4'b1001, 3'd7, 3'd7, 1'b1, 4'd11}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk("R5 ready reached", ready, 1);
  endtask

  task automatic set_cfg(input logic [6:0] v, input logic be, input logic ti);
    {cfg_inorder, cfg_dw_off, cfg_vo_hold, cfg_bus64, cfg_div} = v;
    cfg_big_end = be;
    cfg_tmr_irq = ti;
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int bad;
    logic [8:0] snap;
    rst = 1'b1; pwr_ok = 1'b0; cold_req = 1'b0; warm_req = 1'b0;
    set_cfg(VEC[0][14:8], 1'b1, 1'b0);
    tick(3);
    // R1 reset state
    chk("R1 cold low in reset", cold_rst_n, 0);
    chk("R1 warm low in reset", warm_rst_n, 0);
    chk("R1 ready low in reset", ready, 0);
    rst = 1'b0;
    tick(3);
    chk("R1 cold low without power", cold_rst_n, 0);

    // R2 cold hold from power-good
    pwr_ok = 1'b1;
    n = 0; bad = 0;
    while (!cold_rst_n && n < 1000) begin
      if (warm_rst_n) bad++;
      @(negedge clk); n++;
    end
    chk("R2 cold hold length", n, CH);
    chk("R2 warm held during cold", bad, 0);
    // R3 warm trailing hold
    n = 0; bad = 0;
    while (!warm_rst_n && n < 1000) begin
      if (!cold_rst_n) bad++;
      @(negedge clk); n++;
    end
    chk("R3 warm trail length", n, WH);
    chk("R3 cold stays released", bad, 0);
    // R5 ready one cycle after warm release
    chk("R5 ready low at warm release", ready, 0);
    tick(1);
    chk("R5 ready one cycle later", ready, 1);

    // R8 R10 R11 R12 table walk, each entry through a cold request
    for (int i = 0; i < 8; i++) begin
      set_cfg(VEC[i][14:8], i[0], i[1]);
      cold_req = 1'b1;
      tick(1);
      cold_req = 1'b0;
      wait_ready();
      chk($sformatf("R8 straps vec%0d", i),
          {strap_inorder, strap_dw_off, strap_vo_hold, strap_bus64, strap_div},
          VEC[i][14:8]);
      chk($sformatf("R8 big_end/tmr vec%0d", i), {strap_big_end, strap_tmr_irq}, {i[0], i[1]});
      chk($sformatf("R10 proto vec%0d", i), proto, VEC[i][7:5]);
      chk($sformatf("R11 cfg_err vec%0d", i), cfg_err, VEC[i][4]);
      chk($sformatf("R12 div_x2 vec%0d", i), div_x2, VEC[i][3:0]);
    end

    // R4 warm-only reset; R9 cfg changes during it are ignored
    set_cfg(VEC[1][14:8], 1'b0, 1'b0);
    cold_req = 1'b1; tick(1); cold_req = 1'b0;
    wait_ready();
    snap = {strap_inorder, strap_dw_off, strap_vo_hold, strap_bus64,
            strap_big_end, strap_tmr_irq, strap_div};
    warm_req = 1'b1; tick(1); warm_req = 1'b0;
    set_cfg(VEC[5][14:8], 1'b1, 1'b1);
    n = 0; bad = 0;
    while (!warm_rst_n && n < 1000) begin
      if (!cold_rst_n || ready) bad++;
      @(negedge clk); n++;
    end
    chk("R4 warm-only length", n, WH);
    chk("R4 cold untouched by warm", bad, 0);
    tick(1);
    chk("R5 ready after warm-only", ready, 1);
    chk("R9 straps frozen over warm", {strap_inorder, strap_dw_off, strap_vo_hold,
        strap_bus64, strap_big_end, strap_tmr_irq, strap_div}, snap);
    chk("R9 proto frozen over warm", proto, 1);
    chk("R9 cfg_err frozen over warm", cfg_err, 0);
    chk("R9 div_x2 frozen over warm", div_x2, 5);

    // R7 requests during running cold hold are ignored; cold beats warm
    set_cfg(VEC[2][14:8], 1'b0, 1'b0);
    cold_req = 1'b1; warm_req = 1'b1; tick(1);
    cold_req = 1'b0; warm_req = 1'b0;
    n = 0;
    while (!cold_rst_n && n < 1000) begin
      cold_req = (n == 10);
      warm_req = (n == 20);
      @(negedge clk); n++;
    end
    cold_req = 1'b0; warm_req = 1'b0;
    chk("R7 cold wins and mid-hold requests ignored", n, CH);
    n = 0;
    while (!warm_rst_n && n < 1000) begin
      warm_req = (n == 2);
      @(negedge clk); n++;
    end
    warm_req = 1'b0;
    chk("R7 warm hold not extended", n, WH);
    wait_ready();
    chk("R7 new straps from cold request", proto, 2);

    // R6 power drop during warm hold restarts full cold hold
    cold_req = 1'b1; tick(1); cold_req = 1'b0;
    n = 0;
    while (!cold_rst_n && n < 1000) begin @(negedge clk); n++; end
    tick(2);
    pwr_ok = 1'b0; tick(1); pwr_ok = 1'b1;
    chk("R6 cold asserted on power loss", cold_rst_n, 0);
    chk("R6 warm asserted on power loss", warm_rst_n, 0);
    n = 0;
    while (!cold_rst_n && n < 1000) begin @(negedge clk); n++; end
    chk("R6 full cold hold after power loss", n, CH);
    wait_ready();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule